// File: doc/BRIEF.md
# Serial SAR Converter Interface Controller

This block is the digital front end of a serial successive-approximation converter, seen from the device side. It has no clock of its own. Everything runs from two host-driven inputs: an active-low chip-select and a serial clock. When chip-select falls, the block latches the parallel result that a behavioural stand-in for the analog core presents. It then streams a fixed 16-bit frame out of a serial data pin, one bit per serial-clock falling edge. The pin's output enable is brought out separately so that it can drive a three-state pad.

The same two inputs also control power. The host picks the power mode by choosing how many serial-clock falling edges it lets pass before it raises chip-select again. The block brings out a track/hold indication for the sampling switch, a power-down indication and a frame-valid flag. The frame-valid flag marks the frame that wakes the block as carrying no useful data. The result width is a parameter and may be 12 or 10 bits.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While chip-select is low and fewer than 16 serial-clock falling edges have passed since it fell, `sdata_oe` is 1. The first frame bit is driven from the falling edge of chip-select, before any serial-clock edge. The result at `adc_code` is captured on that falling edge.
- R2: A frame is 16 bits. It holds two 0 bits, then the captured result MSB first in straight binary, then 0 bits: two for a 12-bit result and four for a 10-bit result. After falling edge k of the serial clock (k from 1 to 15), `sdata` carries frame bit k, counted from 0 at the start of the frame.
- R3: On the 16th serial-clock falling edge after chip-select falls, `sdata_oe` goes to 0. It stays 0 for any further edges while chip-select stays low.
- R4: If chip-select rises before the conversion length has passed (14 edges for 12 bits, 12 edges for 10 bits), `sdata_oe` goes to 0 at once and the frame is abandoned. The next frame starts normally.
- R5: While the block is powered, a chip-select rise is handled by the number n of falling edges counted since chip-select fell. For n < 2 the block stays powered. For 2 <= n < 10 it enters power-down (`pwr_down` = 1). For n >= 10 it stays powered.
- R6: While the block is powered down, a chip-select rise with n < 10 leaves it powered down. A rise with n >= 10 powers it up (`pwr_down` = 0).
- R7: `frame_valid` is 1 for a frame that started while the block was powered. It is 0 for a frame that started in power-down, whose data is don't-care.
- R8: In a frame that starts while the block is powered, `track` goes to 0 when chip-select falls. It returns to 1 on the serial-clock rising edge that follows falling edge 13 (12-bit) or falling edge 11 (10-bit). `track` is 1 whenever chip-select is high.
- R9: In a frame that starts in power-down, `track` returns to 1 on the first serial-clock rising edge after chip-select falls.
- R10: Asserting `rst_n` (active low) leaves the block powered, with `sdata_oe` = 0 and `frame_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip-select; frames a conversion and sets the power mode |
| sclk | input | 1 | Serial clock from the host; paces the output and the conversion |
| adc_code | input | RES_W | Parallel result from the analog core stand-in |
| sdata | output | 1 | Serial frame data |
| sdata_oe | output | 1 | Output enable for the three-state data pad |
| track | output | 1 | 1 = track, 0 = hold for the sampling switch |
| pwr_down | output | 1 | 1 while the block is in power-down |
| frame_valid | output | 1 | 1 if the current frame carries a valid result |

## Verification
Some behaviours are checked on every serial-clock falling edge while chip-select is low: the leading and trailing zero padding, the output enable through the frame and its release after the 16th edge, and the hold and track windows of both powered and wake-up frames. The power decision on each chip-select rise, the abort timing and the placement of result bits are not checked that way. Only the bench's frame scenarios show them, because they depend on how many edges the host let pass. Those scenarios run powered, power-down and wake-up frames of random length against a 12-bit and a 10-bit instance, and compare every bit against an independently computed frame.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;

  // Frame geometry shared by all widths.
  localparam int FRAME_LEN   = 16;
  localparam int LEAD_ZEROS  = 2;

  // Power decisions taken from the edge count at the chip-select rise.
  localparam int PD_MIN_EDGE = 2;
  localparam int WAKE_EDGE   = 10;

  typedef enum logic [0:0] {
    PWR_ON  = 1'b0,
    PWR_OFF = 1'b1
  } pwr_e;

  // Falling edge after which the sampling switch may return to track.
  function automatic int track_edge(input int res_w);
    return res_w + 1;
  endfunction

  // Number of zero bits after the result inside a frame.
  function automatic int trail_zeros(input int res_w);
    return FRAME_LEN - LEAD_ZEROS - res_w;
  endfunction

endpackage

// File: rtl/sar_edge_cnt.sv
module sar_edge_cnt #(
  parameter int SAT   = 16,
  parameter int CNT_W = 5
) (
  input  logic             sclk,
  input  logic             cs_n,
  output logic [CNT_W-1:0] edge_cnt
);

  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

  // Chip-select high clears the count asynchronously.
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n)
      edge_cnt <= '0;
    else if (edge_cnt != SAT_V)
      edge_cnt <= edge_cnt + 1'b1;
  end

endmodule

// File: rtl/sar_frame_out.sv
module sar_frame_out
  import sar_ser_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [CNT_W-1:0] edge_cnt,
  input  logic [RES_W-1:0] adc_code,
  output logic             sdata,
  output logic             sdata_oe
);

  localparam int              TRAIL  = trail_zeros(RES_W);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(FRAME_LEN);

  logic [RES_W-1:0]     held_code;
  logic [FRAME_LEN-1:0] frame_word;
  logic [FRAME_LEN-1:0] shifted;

  // Sample instant: the falling edge of chip-select.
  always_ff @(negedge cs_n or negedge rst_n) begin
    if (!rst_n)
      held_code <= '0;
    else
      held_code <= adc_code;
  end

  assign frame_word = {{LEAD_ZEROS{1'b0}}, held_code, {TRAIL{1'b0}}};

  // The edge count selects the bit by shifting the held word.
  always_comb begin
    shifted = frame_word << edge_cnt;
    sdata   = shifted[FRAME_LEN-1];
  end

  assign sdata_oe = rst_n && !cs_n && (edge_cnt < LAST_V);

endmodule

// File: rtl/sar_pwr_ctl.sv
module sar_pwr_ctl
  import sar_ser_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [CNT_W-1:0] edge_cnt,
  output logic             pd_req,
  output logic             wake_req,
  output logic             pwr_down,
  output logic             frame_valid,
  output logic             track
);

  localparam logic [CNT_W-1:0] PD_LO = CNT_W'(PD_MIN_EDGE);
  localparam logic [CNT_W-1:0] PD_HI = CNT_W'(WAKE_EDGE);
  localparam logic [CNT_W-1:0] TE_V  = CNT_W'(track_edge(RES_W));

  pwr_e state;
  logic trk_q;

  assign pd_req   = (edge_cnt >= PD_LO) && (edge_cnt < PD_HI);
  assign wake_req = (edge_cnt >= PD_HI);

  // Power state changes only at a chip-select rise; the count it reads is
  // the value held just before that rise clears it.
  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n)
      state <= PWR_ON;
    else if (state == PWR_ON) begin
      if (pd_req) state <= PWR_OFF;
    end else if (wake_req)
      state <= PWR_ON;
  end

  assign pwr_down = (state == PWR_OFF);

  // A frame carries data only if it started with the block powered.
  always_ff @(negedge cs_n or negedge rst_n) begin
    if (!rst_n)
      frame_valid <= 1'b0;
    else
      frame_valid <= (state == PWR_ON);
  end

  // Return to track on a rising clock edge.
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)
      trk_q <= 1'b0;
    else if (!frame_valid || (edge_cnt >= TE_V))
      trk_q <= 1'b1;
  end

  assign track = cs_n | trk_q;

endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_ser_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] adc_code,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             track,
  output logic             pwr_down,
  output logic             frame_valid
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  // Internal events brought out for the checker.
  logic [CNT_W-1:0] edge_cnt;
  logic             pd_req;
  logic             wake_req;

  sar_edge_cnt #(.SAT(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .sclk     (sclk),
    .cs_n     (cs_n),
    .edge_cnt (edge_cnt)
  );

  sar_frame_out #(.RES_W(RES_W), .CNT_W(CNT_W)) u_out (
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .edge_cnt (edge_cnt),
    .adc_code (adc_code),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
  );

  sar_pwr_ctl #(.RES_W(RES_W), .CNT_W(CNT_W)) u_pwr (
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .edge_cnt    (edge_cnt),
    .pd_req      (pd_req),
    .wake_req    (wake_req),
    .pwr_down    (pwr_down),
    .frame_valid (frame_valid),
    .track       (track)
  );

endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk
  import sar_ser_pkg::*;
#(
  parameter int RES_W = 12
) (
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [4:0] edge_cnt,
  input logic       sdata,
  input logic       sdata_oe,
  input logic       track,
  input logic       frame_valid
);

  localparam logic [4:0] LEAD_V = 5'(LEAD_ZEROS);
  localparam logic [4:0] TAIL_V = 5'(LEAD_ZEROS + RES_W);
  localparam logic [4:0] PRE_V  = 5'(FRAME_LEN - 1);
  localparam logic [4:0] END_V  = 5'(FRAME_LEN);
  localparam logic [4:0] TE_V   = 5'(track_edge(RES_W));

  p_oe_on_r1: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (edge_cnt < END_V) |-> sdata_oe);

  p_lead_zero_r2: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (frame_valid && sdata_oe && edge_cnt < LEAD_V) |-> !sdata);

  p_trail_zero_r2: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (frame_valid && sdata_oe && edge_cnt >= TAIL_V) |-> !sdata);

  p_release_r3: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (edge_cnt == PRE_V) |=> (!sdata_oe && edge_cnt == END_V));

  p_hold_r8: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (frame_valid && edge_cnt < TE_V) |-> !track);

  p_track_back_r8: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (frame_valid && edge_cnt >= TE_V) |-> track);

  p_wake_track_r9: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (!frame_valid && edge_cnt >= 5'd1) |-> track);

endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .edge_cnt    (edge_cnt),
  .sdata       (sdata),
  .sdata_oe    (sdata_oe),
  .track       (track),
  .frame_valid (frame_valid)
);

// File: tb/tb_sar_serial_ctrl.sv
`timescale 1ns/100ps
module tb_sar_serial_ctrl;

  logic        sclk = 1'b1;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [11:0] code12 = '0;
  logic [9:0]  code10 = '0;
  logic sd12, oe12, trk12, pd12, fv12;
  logic sd10, oe10, trk10, pd10, fv10;

  int n_chk  = 0;
  int n_fail = 0;
  int ps     = 0;     // bench power model: 0 powered, 1 down
  bit done   = 1'b0;

  always #4 sclk = ~sclk;   // 125 MHz

  sar_serial_ctrl #(.RES_W(12)) dut (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .adc_code(code12),
    .sdata(sd12), .sdata_oe(oe12), .track(trk12), .pwr_down(pd12),
    .frame_valid(fv12));

  sar_serial_ctrl #(.RES_W(10)) dut10 (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .adc_code(code10),
    .sdata(sd10), .sdata_oe(oe10), .track(trk10), .pwr_down(pd10),
    .frame_valid(fv10));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Frame bit k computed arithmetically: result scaled past its trailing pad.
  function automatic logic exp_bit(input int res_w, input logic [11:0] code, input int k);
    int val;
    val = (res_w == 12) ? int'(code) : int'(code[11:2]);
    val = val * (1 << (14 - res_w));
    return ((val / (1 << (15 - k))) % 2) == 1;
  endfunction

  function automatic logic exp_track(input int res_w, input bit fv, input int k);
    if (fv) return k >= res_w + 2;   // rising edge after falling edge res_w+1
    return k >= 2;                   // first rising edge after chip-select fall
  endfunction

  task automatic run_frame(input int n, input logic [11:0] code);
    bit fv;
    @(posedge sclk);
    #1 code12 = code; code10 = code[11:2];
    #1 cs_n = 1'b0;
    fv = (ps == 0);
    #1;
    chk("R1 oe at select", 32'(oe12), 32'd1);
    chk("R1 oe10 at select", 32'(oe10), 32'd1);
    chk("R7 valid12", 32'(fv12), 32'(fv));
    chk("R7 valid10", 32'(fv10), 32'(fv));
    chk(fv ? "R8 hold12" : "R9 hold12", 32'(trk12), 32'd0);
    if (fv) chk("R1 first bit", 32'(sd12), 32'(exp_bit(12, code, 0)));
    for (int k = 1; k <= n; k++) begin
      @(negedge sclk);
      #1;
      if (k < 16) begin
        chk("R1 oe12 in frame", 32'(oe12), 32'd1);
        chk("R1 oe10 in frame", 32'(oe10), 32'd1);
        if (fv) begin
          chk("R2 bit12", 32'(sd12), 32'(exp_bit(12, code, k)));
          chk("R2 bit10", 32'(sd10), 32'(exp_bit(10, code, k)));
        end
      end else begin
        chk("R3 oe12 released", 32'(oe12), 32'd0);
        chk("R3 oe10 released", 32'(oe10), 32'd0);
      end
      chk(fv ? "R8 track12" : "R9 track12", 32'(trk12), 32'(exp_track(12, fv, k)));
      chk(fv ? "R8 track10" : "R9 track10", 32'(trk10), 32'(exp_track(10, fv, k)));
    end
    if (n > 0) #1;
    cs_n = 1'b1;
    #1;
    chk((n < 14) ? "R4 abort oe12" : "R3 oe12 idle", 32'(oe12), 32'd0);
    chk((n < 12) ? "R4 abort oe10" : "R3 oe10 idle", 32'(oe10), 32'd0);
    chk("R8 track idle", 32'(trk12 & trk10), 32'd1);
    if (ps == 0) begin
      if (n >= 2 && n < 10) ps = 1;
    end else if (n >= 10) ps = 0;
    chk(fv ? "R5 pwr12" : "R6 pwr12", 32'(pd12), 32'(ps));
    chk(fv ? "R5 pwr10" : "R6 pwr10", 32'(pd10), 32'(ps));
    repeat (2) @(posedge sclk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge sclk);
    #1;
    chk("R10 pwr", 32'(pd12 | pd10), 32'd0);
    chk("R10 oe", 32'(oe12 | oe10), 32'd0);
    chk("R10 valid", 32'(fv12 | fv10), 32'd0);
    rst_n = 1'b1;
    // Directed corners
    run_frame(16, 12'hFFF);   // full frame, all ones
    run_frame(16, 12'hA5C);
    run_frame(20, 12'h801);   // extra edges after release
    run_frame(1, 12'h123);    // R5 short rise stays powered
    run_frame(13, 12'h456);   // R4 abort for 12-bit, 10-bit completes
    run_frame(10, 12'h789);   // R5 rise at 10 stays powered
    run_frame(9, 12'h0F0);    // R5 enter power-down
    run_frame(3, 12'h111);    // R6 stays down
    run_frame(12, 12'h222);   // R6 wake, invalid frame
    run_frame(16, 12'h3C3);   // valid again
    run_frame(2, 12'h555);    // R5 lower boundary enters power-down
    run_frame(10, 12'h666);   // R6 wake at boundary
    run_frame(0, 12'h777);    // R4 immediate abort
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int n;
      n = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20) : $urandom_range(14, 17);
      run_frame(n, 12'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule